// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is an 8-bit up-counter that accumulates either external events or gated time. A single input pin is brought into the clock domain through a synchronizer. In event mode, each qualified transition of the pin advances the counter. In gated mode, a free-running tick at one sixty-fourth of the bus clock advances the counter, but only while the pin sits at its active level.

Software controls the block through a small register interface. It can read and write the control bits, the counter and two sticky flags at any time. One flag records counter wrap-around and the other records qualified pin transitions. Each flag has its own enable towards a single interrupt request line.

The control word keeps the accumulator switch at bit 6, the mode select at bit 5 and the polarity select at bit 4. The interrupt enables sit in the low bits.

Top module: `evtacc_core`

## Requirements
- R1: After reset the control word, the counter and both flags read 0 and `irq` is low.
- R2: While the enable bit (control bit 6) is 0, pin activity changes neither the counter nor either flag.
- R3: In event mode (control bit 5 = 0) with polarity (control bit 4) = 1, each rising pin transition adds exactly one to the counter, and falling transitions add nothing.
- R4: In event mode with polarity = 0, each falling pin transition adds one, and rising transitions add nothing.
- R5: A pin change shows up in the counter at the third rising clock edge after the pin changes (two synchronizer stages plus edge detection). A pin that toggles every clock cycle, the highest countable rate, loses no transition.
- R6: In gated mode (control bit 5 = 1), the counter adds one on each tick of a free-running divide-by-64 of the clock while the gate is open. Polarity 0 opens the gate on a high pin and polarity 1 on a low pin. The divider runs from reset and is never restarted, so a gate held open for exactly N×64 clock cycles adds exactly N.
- R7: Writing the counter register loads the written value on the next edge. A load takes priority over an increment due at the same edge, and counting resumes from the loaded value.
- R8: When the counter steps from 0xFF to 0x00, the overflow flag (flag register bit 1) is set.
- R9: The edge flag (flag register bit 0) is set on every qualified pin transition while enabled. In gated mode this is the transition that closes the gate.
- R10: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged.
- R11: `irq` is high exactly when (overflow flag AND control bit 1) OR (edge flag AND control bit 0).
- R12: Register map by `bus_addr`: 0 = control, where only bits 6, 5, 4, 1 and 0 are writable and the rest read 0; 1 = counter; 2 = flags; 3 reads 0. `bus_rdata` is a combinational function of `bus_addr` and the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 1 | Asynchronous event / gate input |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the first rising edge on which the strobe is high. A pin change reaches the counter and the edge flag at the third rising edge, and `irq` follows a flag in the same cycle because it is combinational. The bench drives inputs on falling edges and samples 1 ns after each rising edge, so every value it compares already reflects that edge. The latency check samples the counter on three consecutive cycles after a pin change and expects it to move only on the third. The gated-mode checks hold the gate open for an exact multiple of 64 cycles, so the count does not depend on the divider's phase.

// File: rtl/evtacc_pkg.sv
`timescale 1ns/1ps
package evtacc_pkg;

    localparam int unsigned CNT_W = 8;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_FLAGS = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       spare7;
        logic       enable;
        logic       gated;
        logic       polarity;
        logic [1:0] spare32;
        logic       ovf_ie;
        logic       edge_ie;
    } ctrl_t;

    localparam cnt_t CTRL_WMASK = 8'h73;

    typedef struct packed {
        logic ovf;
        logic edge_hit;
    } flags_t;

    // polarity 1 selects rising transitions, 0 selects falling ones; in gated
    // mode the same choice is the transition that closes the gate
    function automatic logic pick_edge(input logic pol, input logic rise, input logic fall);
        return pol ? rise : fall;
    endfunction

    function automatic logic gate_open(input logic pol, input logic lvl);
        return pol ? ~lvl : lvl;
    endfunction

endpackage

// File: rtl/evtacc_sync.sv
`timescale 1ns/1ps
module evtacc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    // R5: an edge indication lasts a single cycle
    p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
    p_fall_single_r5: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/evtacc_presc.sv
`timescale 1ns/1ps
module evtacc_presc #(
    parameter int unsigned DIV = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)              div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                  div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

    // R6: ticks never come on adjacent cycles
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/evtacc_accum.sv
`timescale 1ns/1ps
module evtacc_accum
    import evtacc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    input  logic   load,
    input  cnt_t   load_val,
    input  logic   edge_evt,
    input  logic   clr_ovf,
    input  logic   clr_edge,
    output cnt_t   count,
    output flags_t flags
);
    logic wrap;

    assign wrap = step & ~load & (count == '1);

    always_ff @(posedge clk) begin
        if (rst)        count <= '0;
        else if (load)  count <= load_val;
        else if (step)  count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (wrap)          flags.ovf <= 1'b1;
            else if (clr_ovf)  flags.ovf <= 1'b0;
            if (edge_evt)      flags.edge_hit <= 1'b1;
            else if (clr_edge) flags.edge_hit <= 1'b0;
        end
    end

    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> count == cnt_t'($past(count) + 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(count));
    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (step && !load && count == '1) |=> flags.ovf);
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr_edge && !edge_evt) |=> !flags.edge_hit);

endmodule

// File: rtl/evtacc_core.sv
`timescale 1ns/1ps
module evtacc_core
    import evtacc_pkg::*;
#(
    parameter int unsigned DIV         = 64,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pin_in,
    output logic       irq
);
    ctrl_t    ctrl_q;
    flags_t   flags;
    cnt_t     count;
    reg_sel_e sel;
    logic     lvl, rise, fall, tick;
    logic     qedge, step, edge_evt;
    logic     wr_ctrl, wr_count, wr_flags;

    assign sel      = reg_sel_e'(bus_addr);
    assign wr_ctrl  = bus_wr & (sel == REG_CTRL);
    assign wr_count = bus_wr & (sel == REG_COUNT);
    assign wr_flags = bus_wr & (sel == REG_FLAGS);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata & CTRL_WMASK);
    end

    evtacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(pin_in),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    evtacc_presc #(.DIV(DIV)) u_presc (
        .clk(clk), .rst(rst), .tick(tick)
    );

    always_comb begin
        qedge    = pick_edge(ctrl_q.polarity, rise, fall);
        edge_evt = ctrl_q.enable & qedge;
        if (ctrl_q.gated) step = ctrl_q.enable & tick & gate_open(ctrl_q.polarity, lvl);
        else              step = ctrl_q.enable & qedge;
    end

    evtacc_accum u_accum (
        .clk(clk), .rst(rst),
        .step(step), .load(wr_count), .load_val(bus_wdata),
        .edge_evt(edge_evt),
        .clr_ovf(wr_flags & bus_wdata[1]),
        .clr_edge(wr_flags & bus_wdata[0]),
        .count(count), .flags(flags)
    );

    always_comb begin
        case (sel)
            REG_CTRL:  bus_rdata = ctrl_q;
            REG_COUNT: bus_rdata = count;
            REG_FLAGS: bus_rdata = {6'd0, flags};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = (flags.ovf & ctrl_q.ovf_ie) | (flags.edge_hit & ctrl_q.edge_ie);

    p_irq_src_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags.ovf || flags.edge_hit));
    p_off_flags_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.enable && !wr_flags) |=> $stable(flags));
    p_ctrl_spare_r12: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl_q.spare7 == 1'b0 && ctrl_q.spare32 == 2'b00));

endmodule

// File: tb/sim_evtacc_core.sv
`timescale 1ns/1ps
module sim_evtacc_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       pin_in = 1'b0;
    logic       irq;

    int total = 0;
    int bad   = 0;
    logic rd_req = 1'b0;
    int    q_exp[$];
    int    q_kind[$];
    string q_tag[$];
    int    m_exp, m_kind, m_act;
    string m_tag;

    always #2.5 clk = ~clk;

    evtacc_core u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq(irq)
    );

    // monitor: pops one expected item per sampled cycle
    always begin
        @(posedge clk);
        #1;
        if (rd_req) begin
            total++;
            if (q_exp.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty actual=%0h expected=none", bus_rdata);
            end else begin
                m_exp  = q_exp.pop_front();
                m_kind = q_kind.pop_front();
                m_tag  = q_tag.pop_front();
                m_act  = m_kind == 1 ? int'(irq) : int'(bus_rdata);
                if (m_act != m_exp) begin
                    bad++;
                    $display("FAIL %s actual=%0h expected=%0h", m_tag, m_act, m_exp);
                end
            end
        end
    end

    task automatic push(input int kind, input int exp, input string tag);
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        push(0, exp, tag);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic irq_is(input int exp, input string tag);
        @(negedge clk);
        push(1, exp, tag);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // pulse the pin away from its idle level and back, n times
    task automatic pulses(input int n, input logic idle_lvl);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pin_in = ~idle_lvl;
            idle(3);
            pin_in = idle_lvl;
            idle(3);
        end
        idle(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0, 0, "R1 ctrl");
        rd(2'd1, 0, "R1 count");
        rd(2'd2, 0, "R1 flags");
        irq_is(0, "R1 irq");

        // R2 disabled: rising polarity but enable off
        wr(2'd0, 8'h10);
        pulses(3, 1'b0);
        rd(2'd1, 0, "R2 count unchanged");
        rd(2'd2, 0, "R2 flags unchanged");

        // R3 rising edges, R12 control readback
        wr(2'd0, 8'h50);
        rd(2'd0, 8'h50, "R12 ctrl readback");
        pulses(3, 1'b0);
        rd(2'd1, 3, "R3 three rising edges");
        rd(2'd2, 1, "R9 edge flag event mode");
        wr(2'd2, 8'h01);
        rd(2'd2, 0, "R10 edge flag cleared");

        // R5 latency: count moves on the third edge
        @(negedge clk);
        pin_in = 1'b1; bus_addr = 2'd1;
        push(0, 3, "R5 edge1"); push(0, 3, "R5 edge2"); push(0, 4, "R5 edge3");
        rd_req = 1'b1;
        idle(3);
        rd_req = 1'b0;
        pin_in = 1'b0;
        idle(4);
        // R5 toggle every cycle: four rising transitions
        for (int i = 0; i < 8; i++) begin
            pin_in = (i % 2 == 0);
            @(negedge clk);
        end
        pin_in = 1'b0;
        idle(4);
        rd(2'd1, 8, "R5 full-rate toggling");

        // R4 falling edges
        wr(2'd0, 8'h40);
        pulses(2, 1'b0);
        rd(2'd1, 10, "R4 two falling edges");
        wr(2'd2, 8'h03);

        // R7 load, R8 wrap
        wr(2'd1, 8'hFD);
        rd(2'd1, 8'hFD, "R7 load value");
        pulses(2, 1'b0);
        rd(2'd1, 8'hFF, "R7 counting resumes");
        pulses(1, 1'b0);
        rd(2'd1, 0, "R8 wrap to zero");
        rd(2'd2, 3, "R8 overflow and edge flags");

        // R7 load wins over a simultaneous increment
        @(negedge clk); pin_in = 1'b1;
        idle(4);
        pin_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 8'h20; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        idle(2);
        rd(2'd1, 8'h20, "R7 load priority");

        // R10 writing zero leaves flags, R11 interrupt gating
        wr(2'd2, 8'h00);
        rd(2'd2, 3, "R10 zero write no effect");
        irq_is(0, "R11 no enables");
        wr(2'd0, 8'h42);
        irq_is(1, "R11 overflow enabled");
        wr(2'd2, 8'h02);
        rd(2'd2, 1, "R10 overflow cleared");
        irq_is(0, "R11 edge flag masked");
        wr(2'd0, 8'h41);
        irq_is(1, "R11 edge enabled");
        wr(2'd2, 8'h01);
        irq_is(0, "R11 all clear");

        // R12 writable bits and unused address
        wr(2'd0, 8'hFF);
        rd(2'd0, 8'h73, "R12 writable mask");
        wr(2'd0, 8'h00);
        rd(2'd3, 0, "R12 unused address");
        wr(2'd2, 8'h03);

        // R6 gated, high level opens gate, 5 x 64 cycles
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h60);
        @(negedge clk); pin_in = 1'b1;
        idle(320);
        pin_in = 1'b0;
        idle(6);
        rd(2'd1, 5, "R6 high gate 320 cycles");
        rd(2'd2, 1, "R9 trailing edge gated high");

        // R6 gated, low level opens gate, 2 x 64 cycles
        wr(2'd0, 8'h30);
        @(negedge clk); pin_in = 1'b1;
        idle(4);
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h70);
        @(negedge clk); pin_in = 1'b0;
        idle(128);
        pin_in = 1'b1;
        idle(6);
        rd(2'd1, 2, "R6 low gate 128 cycles");
        rd(2'd2, 1, "R9 trailing edge gated low");

        idle(4);
        if (q_exp.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", q_exp.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule